// File: doc/BRIEF.md
# Program Counter Breakpoint Comparator

This block watches the processor's program counter (PC) and flags when it reaches one of four programmed breakpoint addresses. Four breakpoint slots and one address-mask register are loaded over a debug register-write port: a write strobe, a 5-bit register code and a 32-bit data word. No register can be read back through this block. Each clock the block compares the presented PC against every slot and registers a per-slot hit flag plus a combined hit. A debug controller uses the combined hit to decide when to halt or signal the processor.

Slot 0 is the flexible one. It compares all 32 PC bits against its stored address, with bits excluded wherever the mask register holds a 1. It has no valid bit of its own; an external enable input, driven by the trigger configuration logic, arms it. Slots 1 to 3 are simpler. Each compares PC bits 31:1 against its stored bits 31:1, ignores the mask entirely, and is armed by bit 0 of its own register, which serves as a valid bit.

The block has no sequencing state. Its only storage is the register bank and one output register stage. A hit is reported on the clock edge that follows the cycle in which the PC is presented.

Top module: `pc_brkpt_unit`

## Requirements
- R1: After reset, hit_vec and hit_any are 0, every slot's stored word including the valid bits of slots 1 to 3 is zero, and the mask register is zero.
- R2: When slot0_en is 1, hit_vec[0] is set for a presented PC exactly when ((pc XOR slot0 address) AND NOT mask) equals zero. A mask bit of 1 excludes that address bit.
- R3: When slot0_en is 0, hit_vec[0] is 0 for any PC and any mask.
- R4: The mask register has no effect on slots 1 to 3, including when every mask bit is 1.
- R5: For slots 1 to 3, the hit requires pc[31:1] to equal bits 31:1 of the slot's register. pc[0] never affects these slots.
- R6: For a slot 1 to 3, the hit additionally requires bit 0 of its register (the valid bit) to be 1. When that bit is 0 the slot never hits.
- R7: A write lands only when wr_en is 1. The register codes are: 5'h08 for slot 0, 5'h18 for slot 1, 5'h1A for slot 2, 5'h1B for slot 3, and 5'h0F for the mask. A write with any other code, or with wr_en at 0, changes nothing.
- R8: hit_vec and hit_any reflect the PC, the enable and the register contents sampled at the previous rising edge. A register written at an edge is compared from the next cycle onward.
- R9: hit_any is the OR of the four hit_vec bits.
- R10: Slot 0 compares bit 0 too. With no mask, a PC differing from the slot 0 address only in bit 0 does not hit slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_code | input | 5 | Register code selecting the write target |
| wr_data | input | 32 | Write data |
| pc | input | 32 | Current program counter |
| slot0_en | input | 1 | Arms slot 0 comparison |
| hit_vec | output | 4 | Registered per-slot hit flags |
| hit_any | output | 1 | Registered OR of the per-slot hits |

## Verification
Each hit result is due one rising edge after the PC and enable are presented. A register write is due one edge after its strobe, so a PC presented in the following cycle already compares against the new contents. The bench drives every input on a falling edge and samples hit_vec and hit_any on the next falling edge, which lies after exactly one rising edge. Each write is held for one full cycle before the next PC goes out, so every expected value is taken from a model of the registers updated by the write sequence.

// File: rtl/pcbp_pkg.sv
package pcbp_pkg;
    localparam int unsigned NUM_SLOTS = 4;
    localparam int unsigned CODE_W    = 5;

    localparam logic [CODE_W-1:0] CODE_SLOT0 = 5'h08;
    localparam logic [CODE_W-1:0] CODE_SLOT1 = 5'h18;
    localparam logic [CODE_W-1:0] CODE_SLOT2 = 5'h1A;
    localparam logic [CODE_W-1:0] CODE_SLOT3 = 5'h1B;
    localparam logic [CODE_W-1:0] CODE_MASK  = 5'h0F;

    // register code that selects breakpoint slot idx
    function automatic logic [CODE_W-1:0] slot_code(input int unsigned idx);
        logic [CODE_W-1:0] c;
        unique case (idx)
            0:       c = CODE_SLOT0;
            1:       c = CODE_SLOT1;
            2:       c = CODE_SLOT2;
            default: c = CODE_SLOT3;
        endcase
        return c;
    endfunction

    function automatic logic code_known(input logic [CODE_W-1:0] c);
        return (c == CODE_SLOT0) || (c == CODE_SLOT1) || (c == CODE_SLOT2) ||
               (c == CODE_SLOT3) || (c == CODE_MASK);
    endfunction
endpackage

// File: rtl/pcbp_regfile.sv
module pcbp_regfile
    import pcbp_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [CODE_W-1:0]                  wr_code,
    input  logic [ADDR_W-1:0]                  wr_data,
    output logic [NUM_SLOTS-1:0][ADDR_W-1:0]   bp_word,
    output logic [ADDR_W-1:0]                  bp_mask
);

    // one write-only word per slot; for slots above 0 bit 0 is the valid bit
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bp_word[s] <= '0;
            end else if (wr_en && (wr_code == slot_code(s))) begin
                bp_word[s] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bp_mask <= '0;
        end else if (wr_en && (wr_code == CODE_MASK)) begin
            bp_mask <= wr_data;
        end
    end

    // R7: strobes that are off or carry an unknown code leave the bank alone
    p_ignore_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || !code_known(wr_code)) |=> ($stable(bp_word) && $stable(bp_mask)));

    // R1: valid bits are clear one edge after reset is seen low
    p_rst_valid_r1: assert property (@(posedge clk)
        !rst_n |=> (bp_word[1][0] == 1'b0 && bp_word[2][0] == 1'b0 &&
                    bp_word[3][0] == 1'b0 && bp_mask == '0));

endmodule

// File: rtl/pcbp_cmp.sv
module pcbp_cmp #(
    parameter int unsigned ADDR_W   = 32,
    parameter bit          HAS_MASK = 1'b0
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] bp_addr,
    input  logic [ADDR_W-1:0] bp_mask,
    input  logic              arm,
    output logic              match
);
    // the masked variant covers every bit; the plain one drops bit 0,
    // which holds the valid flag there
    localparam logic [ADDR_W-1:0] KEEP =
        HAS_MASK ? {ADDR_W{1'b1}} : {{(ADDR_W-1){1'b1}}, 1'b0};

    logic [ADDR_W-1:0] diff;

    always_comb begin
        diff  = (pc ^ bp_addr) & ~bp_mask & KEEP;
        match = arm && (diff == '0);
    end
endmodule

// File: rtl/pc_brkpt_unit.sv
module pc_brkpt_unit
    import pcbp_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [CODE_W-1:0]    wr_code,
    input  logic [ADDR_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    pc,
    input  logic                 slot0_en,
    output logic [NUM_SLOTS-1:0] hit_vec,
    output logic                 hit_any
);

    logic [NUM_SLOTS-1:0][ADDR_W-1:0] bp_word;
    logic [ADDR_W-1:0]                bp_mask;
    logic [NUM_SLOTS-1:0]             match_now;

    pcbp_regfile #(.ADDR_W(ADDR_W)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_code (wr_code),
        .wr_data (wr_data),
        .bp_word (bp_word),
        .bp_mask (bp_mask)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cmp
        if (s == 0) begin : g_masked
            pcbp_cmp #(.ADDR_W(ADDR_W), .HAS_MASK(1'b1)) cmp_i (
                .pc      (pc),
                .bp_addr (bp_word[s]),
                .bp_mask (bp_mask),
                .arm     (slot0_en),
                .match   (match_now[s])
            );
        end else begin : g_plain
            pcbp_cmp #(.ADDR_W(ADDR_W), .HAS_MASK(1'b0)) cmp_i (
                .pc      (pc),
                .bp_addr (bp_word[s]),
                .bp_mask ({ADDR_W{1'b0}}),
                .arm     (bp_word[s][0]),
                .match   (match_now[s])
            );
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_vec <= '0;
            hit_any <= 1'b0;
        end else begin
            hit_vec <= match_now;
            hit_any <= |match_now;
        end
    end

    // R9: combined flag agrees with the per-slot flags
    p_any_is_or_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any == (|hit_vec));

    // R3: a disarmed slot 0 never reports
    p_slot0_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(slot0_en)) |-> !hit_vec[0]);

    for (genvar s = 1; s < NUM_SLOTS; s++) begin : g_chk
        // R6: a clear valid bit keeps the slot silent
        p_valid_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(bp_word[s][0])) |-> !hit_vec[s]);
        // R4 and R5: an upper-address mismatch is never rescued by the mask
        p_unmasked_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && ($past(pc[ADDR_W-1:1]) != $past(bp_word[s][ADDR_W-1:1])))
            |-> !hit_vec[s]);
    end

endmodule

// File: tb/pc_brkpt_unit_tb.sv
`timescale 1ns/1ps
module pc_brkpt_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_code = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] pc = '0;
    logic        slot0_en = 1'b0;
    logic [3:0]  hit_vec;
    logic        hit_any;

    int checks = 0;
    int fails  = 0;

    // bench-side picture of the register bank
    logic [31:0] m_word [4];
    logic [31:0] m_mask;

    always #4 clk = ~clk;

    pc_brkpt_unit dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_code(wr_code),
        .wr_data(wr_data), .pc(pc), .slot0_en(slot0_en),
        .hit_vec(hit_vec), .hit_any(hit_any)
    );

    function automatic logic [3:0] expect_hits(input logic [31:0] p, input logic e);
        logic [3:0] r;
        r[0] = e && (((p ^ m_word[0]) & ~m_mask) == 32'h0);
        for (int s = 1; s < 4; s++)
            r[s] = m_word[s][0] && (p[31:1] == m_word[s][31:1]);
        return r;
    endfunction

    // called on a falling edge; returns on a falling edge
    task automatic do_write(input logic en, input logic [4:0] code, input logic [31:0] d);
        wr_en = en; wr_code = code; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (en) begin
            case (code)
                5'h08: m_word[0] = d;
                5'h18: m_word[1] = d;
                5'h1A: m_word[2] = d;
                5'h1B: m_word[3] = d;
                5'h0F: m_mask    = d;
                default: ;
            endcase
        end
    endtask

    task automatic present(input logic [31:0] p, input logic e, input string tag);
        logic [3:0] exp_v;
        exp_v = expect_hits(p, e);
        pc = p; slot0_en = e;
        @(negedge clk);
        checks++;
        if (hit_vec !== exp_v || hit_any !== (|exp_v)) begin
            fails++;
            $display("FAIL %s: pc=%h en=%b hit_vec=%b hit_any=%b expected %b/%b",
                     tag, p, e, hit_vec, hit_any, exp_v, |exp_v);
        end
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int s = 0; s < 4; s++) m_word[s] = '0;
        m_mask = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: outputs idle out of reset
        checks++;
        if (hit_vec !== 4'b0 || hit_any !== 1'b0) begin
            fails++;
            $display("FAIL R1: hit_vec=%b hit_any=%b expected 0000/0", hit_vec, hit_any);
        end
        present(32'h0, 1'b0, "R1 cleared valids, slot0 off");
        present(32'h0, 1'b1, "R1 slot0 address zero");
        present(32'h1, 1'b1, "R1 R10 bit0 differs");

        // R2 R8: sweep every low-nibble mask against every low-nibble PC
        do_write(1'b1, 5'h08, 32'h1000_0005);
        present(32'h1000_0005, 1'b1, "R8 write seen next cycle");
        for (int m = 0; m < 16; m++) begin
            do_write(1'b1, 5'h0F, {28'h0, 4'(m)});
            for (int l = 0; l < 16; l++)
                present({28'h1000_000, 4'(l)}, 1'b1, "R2 masked sweep");
            present(32'h1000_0005, 1'b0, "R3 slot0 disarmed");
            present(32'h1100_0005, 1'b1, "R2 upper bits differ");
        end

        // R10: bit 0 counts when unmasked
        do_write(1'b1, 5'h0F, 32'h0);
        do_write(1'b1, 5'h08, 32'h1000_0004);
        present(32'h1000_0004, 1'b1, "R10 exact");
        present(32'h1000_0005, 1'b1, "R10 bit0 set");

        // slots 1..3 with mask fully open to show R4
        do_write(1'b1, 5'h18, 32'h2000_0011);
        do_write(1'b1, 5'h1A, 32'h2000_0020);
        do_write(1'b1, 5'h1B, 32'h3000_0041);
        do_write(1'b1, 5'h0F, 32'hFFFF_FFFF);
        for (int base = 0; base < 3; base++) begin
            logic [31:0] b;
            b = (base == 0) ? 32'h2000_0010 : (base == 1) ? 32'h2000_0020 : 32'h3000_0040;
            for (int d = -2; d < 4; d++) begin
                present(b + 32'(d), 1'b1, "R4 R5 R6 upper slots");
                present(b + 32'(d), 1'b0, "R3 R5 R6 slot0 off");
            end
        end

        // R7: off strobe and foreign codes change nothing
        do_write(1'b0, 5'h18, 32'h5555_5555);
        do_write(1'b1, 5'h09, 32'h0);
        do_write(1'b1, 5'h19, 32'h0);
        do_write(1'b0, 5'h0F, 32'h0);
        present(32'h2000_0010, 1'b0, "R7 slot1 kept");
        present(32'h3000_0041, 1'b0, "R7 slot3 kept");
        present(32'h7777_0000, 1'b1, "R7 mask kept");

        // R6: arm slot 2 then disarm slot 1
        do_write(1'b1, 5'h1A, 32'h2000_0021);
        present(32'h2000_0021, 1'b0, "R6 slot2 armed");
        do_write(1'b1, 5'h18, 32'h2000_0010);
        present(32'h2000_0010, 1'b0, "R6 slot1 disarmed");

        // R9 R8: several slots at once, then a miss right after a hit
        do_write(1'b1, 5'h18, 32'h4000_0001);
        do_write(1'b1, 5'h1B, 32'h4000_0001);
        do_write(1'b1, 5'h0F, 32'h0);
        do_write(1'b1, 5'h08, 32'h4000_0000);
        present(32'h4000_0000, 1'b1, "R9 three slots");
        present(32'h4000_0002, 1'b1, "R8 R9 miss after hit");
        present(32'h4000_0001, 1'b1, "R5 R10 pc bit0");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule